// File: doc/BRIEF.md
# Programmable Pulse Train Generator

This block is a single-channel serial waveform source. Software loads a bit pattern, a bit period and a repeat setting through a small write/read register port, then sets the enable bit. The channel shifts the pattern out on one output pin, most significant used bit first. It can send the pattern a fixed number of times, with a low gap of whole bit periods between sends, or repeat it until it is disabled. A reserved length code turns the same engine into a square-wave source whose output toggles once per period.

When a finite run ends, the channel clears its own enable, parks the pin low and raises a done flag on `irq`. Software clears that flag by writing a one to it. While the channel runs, its configuration registers are locked. Register addresses: 0 holds the rate and mode, 1 the pattern, 2 the loop setting, 3 the enable bit and 4 the flags.

Top module: `ptrain_gen`

## Requirements
- R1: After reset `pt_out` and `irq` are 0, and every register reads back 0.
- R2: In pattern mode the first bit appears on `pt_out` in the cycle after the enabling write. Each bit is held for exactly `rate` clock cycles (rate = address 0 bits 26:0). Bits are sent from bit L-1 down to bit 0 of the pattern register.
- R3: The length code in address 0 bits 31:27, with value c from 1 to 31, selects a pattern length of L = c+1 bits.
- R4: A loop count N > 0 (address 2 bits 15:0) sends the pattern N times. At the end of the last bit period the enable clears, `pt_out` goes low and the done flag (address 4 bit 0, also `irq`) sets.
- R5: A loop count of 0 repeats the pattern until the channel is disabled.
- R6: A loop delay D (address 2 bits 27:16) puts D bit periods of low output between repeats and none after the last one.
- R7: Length code 0 selects square wave. The output is high for `rate` cycles, then low for `rate` cycles, and so on.
- R8: A rate of 1 gives one bit, or one toggle, per clock cycle.
- R9: Writing enable (address 3, bit 0 = 1) while the rate is 0 is ignored. The channel stays disabled.
- R10: While the channel is enabled, writes to addresses 0 to 2 are ignored, and so is a further write of enable = 1.
- R11: Writing enable = 0 drives `pt_out` low on the next cycle. A later enable starts again from the first pattern bit and the first repeat.
- R12: Writing 1 to flag bit 0 clears the done flag. Writing 0 leaves it unchanged.
- R13: Reads return the written configuration, the live enable bit and the done flag one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| pt_out | output | 1 | Serial pulse train output |
| irq | output | 1 | Done flag |

## Verification
A wrong bit index or divider count shows on `pt_out` within one bit period. The output then holds the wrong level or switches a cycle early or late, so the bench compares it against a per-cycle queue of expected levels. A wrong repeat counter or gap counter stays hidden until the end of a repeat. It then shows as a missing or extra low gap, or as `irq` rising one pattern too early or too late. Because of this, the bench runs finite loops to completion and also holds an endless loop across several repeats.

// File: rtl/ptrain_pkg.sv
package ptrain_pkg;
  localparam int DATA_W  = 32;
  localparam int RATE_W  = 27;
  localparam int LEN_LSB = 27;
  localparam int LEN_W   = 5;
  localparam int CNT_W   = 16;
  localparam int DLY_LSB = 16;
  localparam int DLY_W   = 12;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_RATE = 3'd0;
  localparam logic [ADDR_W-1:0] A_PAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOOP = 3'd2;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;
endpackage

// File: rtl/ptrain_regs.sv
module ptrain_regs
  import ptrain_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              run,
  input  logic              finish,
  output logic              start,
  output logic              stop,
  output logic [RATE_W-1:0] rate,
  output logic [LEN_W-1:0]  len_code,
  output logic [DATA_W-1:0] pattern,
  output logic [CNT_W-1:0]  loops,
  output logic [DLY_W-1:0]  gap,
  output logic              done
);
  logic cfg_wr;
  assign cfg_wr = wr_en && !run;
  assign start  = wr_en && (wr_addr == A_EN) && wr_data[0] && !run && (rate != '0);
  assign stop   = wr_en && (wr_addr == A_EN) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rate     <= '0;
      len_code <= '0;
      pattern  <= '0;
      loops    <= '0;
      gap      <= '0;
    end else if (cfg_wr) begin
      case (wr_addr)
        A_RATE: begin
          rate     <= wr_data[RATE_W-1:0];
          len_code <= wr_data[LEN_LSB +: LEN_W];
        end
        A_PAT:  pattern <= wr_data;
        A_LOOP: begin
          loops <= wr_data[CNT_W-1:0];
          gap   <= wr_data[DLY_LSB +: DLY_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else if (finish) done <= 1'b1;
    else if (wr_en && (wr_addr == A_FLAG) && wr_data[0]) done <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        A_RATE:  rd_data <= {len_code, rate};
        A_PAT:   rd_data <= pattern;
        A_LOOP:  rd_data <= {{(DATA_W-DLY_LSB-DLY_W){1'b0}}, gap, loops};
        A_EN:    rd_data <= {{(DATA_W-1){1'b0}}, run};
        A_FLAG:  rd_data <= {{(DATA_W-1){1'b0}}, done};
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ptrain_div.sv
module ptrain_div #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         run,
  input  logic [W-1:0] rate,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !(run || start)) cnt <= '0;
    else if (start)             cnt <= rate;
    else if (cnt == W'(1))      cnt <= rate;
    else                        cnt <= cnt - W'(1);
  end

  assign tick = run && (cnt == W'(1));
endmodule

// File: rtl/ptrain_seq.sv
module ptrain_seq
  import ptrain_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              tick,
  input  logic [LEN_W-1:0]  len_code,
  input  logic [DATA_W-1:0] pattern,
  input  logic [CNT_W-1:0]  loops,
  input  logic [DLY_W-1:0]  gap,
  output logic              run,
  output logic              out,
  output logic              finish
);
  logic [LEN_W-1:0] idx;
  logic [CNT_W-1:0] rep;
  logic [DLY_W-1:0] gcnt;
  logic             in_gap;
  logic             sq;
  logic             last_bit;

  assign sq       = (len_code == '0);
  assign last_bit = !sq && !in_gap && (idx == '0);
  assign finish   = run && tick && !stop && last_bit &&
                    (loops != '0) && (rep == loops - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; out <= 1'b0; idx <= '0; rep <= '0; in_gap <= 1'b0; gcnt <= '0;
    end else if (stop) begin
      run <= 1'b0; out <= 1'b0; in_gap <= 1'b0;
    end else if (start) begin
      run    <= 1'b1;
      rep    <= '0;
      in_gap <= 1'b0;
      idx    <= len_code;
      out    <= sq ? 1'b1 : pattern[len_code];
    end else if (tick) begin
      if (sq) begin
        out <= !out;
      end else if (in_gap) begin
        if (gcnt == DLY_W'(1)) begin
          in_gap <= 1'b0;
          idx    <= len_code;
          out    <= pattern[len_code];
        end else begin
          gcnt <= gcnt - DLY_W'(1);
        end
      end else if (idx != '0) begin
        idx <= idx - LEN_W'(1);
        out <= pattern[idx - LEN_W'(1)];
      end else if (finish) begin
        run <= 1'b0;
        out <= 1'b0;
      end else begin
        rep <= rep + CNT_W'(1);
        if (gap != '0) begin
          in_gap <= 1'b1;
          gcnt   <= gap;
          out    <= 1'b0;
        end else begin
          idx <= len_code;
          out <= pattern[len_code];
        end
      end
    end
  end
endmodule

// File: rtl/ptrain_gen.sv
module ptrain_gen
  import ptrain_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pt_out,
  output logic              irq
);
  logic              start, stop, tick, run, finish;
  logic [RATE_W-1:0] rate;
  logic [LEN_W-1:0]  len_code;
  logic [DATA_W-1:0] pattern;
  logic [CNT_W-1:0]  loops;
  logic [DLY_W-1:0]  gap;

  ptrain_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .run(run), .finish(finish), .start(start), .stop(stop),
    .rate(rate), .len_code(len_code), .pattern(pattern),
    .loops(loops), .gap(gap), .done(irq)
  );

  ptrain_div #(.W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .start(start), .run(run), .rate(rate), .tick(tick)
  );

  ptrain_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .tick(tick),
    .len_code(len_code), .pattern(pattern), .loops(loops), .gap(gap),
    .run(run), .out(pt_out), .finish(finish)
  );
endmodule

// File: rtl/ptrain_chk.sv
module ptrain_chk
  import ptrain_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              run,
  input logic              pt_out,
  input logic              irq,
  input logic [RATE_W-1:0] rate,
  input logic [LEN_W-1:0]  len_code,
  input logic [DATA_W-1:0] pattern
);
  p_idle_low_r11: assert property (@(posedge clk) disable iff (rst)
    !run |-> !pt_out);

  p_irq_hold_r12: assert property (@(posedge clk) disable iff (rst)
    irq && !(wr_en && wr_addr == A_FLAG && wr_data[0]) |=> irq);

  p_irq_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (!run && $past(run)));

  p_cfg_lock_r10: assert property (@(posedge clk) disable iff (rst)
    run && wr_en && wr_addr == A_PAT |=> $stable(pattern));

  p_zero_rate_r9: assert property (@(posedge clk) disable iff (rst)
    !run && wr_en && wr_addr == A_EN && wr_data[0] && rate == '0 |=> !run);

  p_sq_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && len_code == '0 && rate == RATE_W'(1) |-> pt_out != $past(pt_out));
endmodule

bind ptrain_gen ptrain_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run(run), .pt_out(pt_out), .irq(irq), .rate(rate), .len_code(len_code),
  .pattern(pattern)
);

// File: tb/ptrain_gen_bench.sv
module ptrain_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pt_out, irq;

  int checks = 0, failures = 0, cyc = 0;
  string cur_req = "R1";

  ptrain_gen u_ptrain_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pt_out(pt_out), .irq(irq)
  );

  always #2 clk = ~clk;

  // reference model: per-cycle queue of expected output levels
  int unsigned m_rate, m_len, m_loops, m_gap;
  logic [31:0] m_pat;
  logic m_en, m_done, exp_out;
  bit q[$];

  function automatic void push_rep(bit with_gap);
    if (with_gap) for (int i = 0; i < m_gap * m_rate; i++) q.push_back(1'b0);
    for (int b = m_len; b >= 0; b--)
      for (int r = 0; r < m_rate; r++) q.push_back(m_pat[b]);
  endfunction

  function automatic void push_sq();
    for (int r = 0; r < m_rate; r++) q.push_back(1'b1);
    for (int r = 0; r < m_rate; r++) q.push_back(1'b0);
  endfunction

  always @(posedge clk) begin
    bit en_before, set_done;
    set_done = 0;
    en_before = m_en;
    if (rst) begin
      m_rate = 0; m_len = 0; m_loops = 0; m_gap = 0; m_pat = '0;
      m_en = 0; m_done = 0; exp_out = 0; q.delete();
    end else begin
      if (m_en) begin
        if (wr_en && wr_addr == 3'd3 && !wr_data[0]) begin
          m_en = 0; exp_out = 0; q.delete();
        end else begin
          if (q.size() == 0) begin
            if (m_len == 0) push_sq();
            else if (m_loops == 0) push_rep(1);
          end
          if (q.size() == 0) begin
            m_en = 0; exp_out = 0; set_done = 1;
          end else exp_out = q.pop_front();
        end
      end else if (wr_en && wr_addr == 3'd3 && wr_data[0] && m_rate != 0) begin
        q.delete();
        if (m_len == 0) push_sq();
        else if (m_loops == 0) push_rep(0);
        else for (int k = 0; k < m_loops; k++) push_rep(k > 0);
        exp_out = q.pop_front();
        m_en = 1;
      end
      if (wr_en && !en_before) begin
        case (wr_addr)
          3'd0: begin m_rate = wr_data[26:0]; m_len = wr_data[31:27]; end
          3'd1: m_pat = wr_data;
          3'd2: begin m_loops = wr_data[15:0]; m_gap = wr_data[27:16]; end
          default: ;
        endcase
      end
      if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_done = 0;
      if (set_done) m_done = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (pt_out !== exp_out || irq !== m_done) begin
        failures++;
        $display("FAIL %s cyc=%0d out=%b irq=%b expected out=%b irq=%b",
                 cur_req, cyc, pt_out, irq, exp_out, m_done);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 0;
    @(negedge clk);
    checks++;
    if (rd_data !== expv) begin
      failures++;
      $display("FAIL %s read addr %0d got %h expected %h", tag, a, rd_data, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    cur_req = "R1";
    for (int a = 0; a < 5; a++) rd(3'(a), 32'h0, "R1");

    // R2 R3 R4 R6: 8-bit pattern, rate 3, two repeats, gap of 2
    cur_req = "R2/R3/R4/R6";
    wr(3'd0, (32'd7 << 27) | 32'd3);
    wr(3'd1, 32'h0000_00B2);
    wr(3'd2, (32'd2 << 16) | 32'd2);
    rd(3'd0, (32'd7 << 27) | 32'd3, "R13");
    rd(3'd2, (32'd2 << 16) | 32'd2, "R13");
    wr(3'd3, 32'd1);
    idle(70);
    rd(3'd3, 32'd0, "R4");
    rd(3'd4, 32'd1, "R4");

    cur_req = "R12";
    wr(3'd4, 32'd0);
    rd(3'd4, 32'd1, "R12");
    wr(3'd4, 32'd1);
    rd(3'd4, 32'd0, "R12");

    // R8: rate 1, full 32-bit pattern, one pass
    cur_req = "R8/R3";
    wr(3'd0, (32'd31 << 27) | 32'd1);
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd2, 32'd1);
    wr(3'd3, 32'd1);
    idle(40);
    wr(3'd4, 32'd1);

    // R7: square wave rate 2, then R11 stop
    cur_req = "R7";
    wr(3'd0, 32'd2);
    wr(3'd3, 32'd1);
    idle(21);
    cur_req = "R11";
    wr(3'd3, 32'd0);
    idle(5);

    // R8 on square wave
    cur_req = "R7/R8";
    wr(3'd0, 32'd1);
    wr(3'd3, 32'd1);
    idle(9);
    wr(3'd3, 32'd0);

    // R5 R10: endless 4-bit pattern, gap 1, rate 2
    cur_req = "R5/R6";
    wr(3'd0, (32'd3 << 27) | 32'd2);
    wr(3'd1, 32'h0000_0009);
    wr(3'd2, (32'd1 << 16) | 32'd0);
    wr(3'd3, 32'd1);
    idle(30);
    cur_req = "R10";
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'd5);
    wr(3'd3, 32'd1);
    rd(3'd1, 32'h0000_0009, "R10");
    rd(3'd0, (32'd3 << 27) | 32'd2, "R10");
    idle(30);
    cur_req = "R11";
    wr(3'd3, 32'd0);
    rd(3'd3, 32'd0, "R11");
    idle(3);
    wr(3'd3, 32'd1);
    rd(3'd3, 32'd1, "R11");
    idle(12);
    wr(3'd3, 32'd0);

    // R9: zero rate cannot start the channel
    cur_req = "R9";
    wr(3'd0, (32'd7 << 27));
    wr(3'd3, 32'd1);
    rd(3'd3, 32'd0, "R9");
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule